// File: doc/BRIEF.md
# Exception Machine-State Save and Restore Unit

This block keeps the 64-bit machine state word of a small processor core together with its two exception save registers: one for the resume address and one for the saved state. Bit numbering is big-endian, so big-endian bit n is vector index 63-n. When the core takes an interrupt, the unit stores the resume address. It forms the saved-state word from the current machine state, and the interrupt's cause fields replace the state bits at their positions. It then loads the machine state with a fixed supervisor entry value.

A return-from-interrupt strobe reloads the machine state from the saved-state word, with every cause-field position forced to zero. This stops indicators such as memory-translation-miss details from leaking into live state. In the same step the unit sends the saved resume address back to instruction fetch with a one-cycle valid pulse. Software can also load any of the three registers through a simple write port.

Top module: `exc_state_unit`

## Requirements
- R1: While reset is high, the machine state becomes RESET_MSR (default 64'h8000_0000_0000_0000), both save registers become zero and redirect_valid is low.
- R2: An interrupt request (intr_valid high at a clock edge) loads the resume-address register with intr_pc, visible on srr0_q after that edge.
- R3: On interrupt entry, the saved-state bits at big-endian 0-32, 37-41 and 48-63 equal the machine state that was in force, with no bit filtered out.
- R4: On interrupt entry, big-endian bits 33-36 of the saved state take intr_cause_hi (bit [3] at position 33) and bits 42-47 take intr_cause_lo (bit [5] at position 42), whatever the machine state held there.
- R5: On interrupt entry, the machine state becomes ENTRY_MSR (default 64'h8000_0000_0000_0000), whose external-interrupt-enable (big-endian 48) and problem-state (big-endian 49) bits are zero.
- R6: A return strobe without an interrupt loads the machine state with the saved-state word ANDed with the complement of 64'h0000_0000_783F_0000.
- R7: The vector-unit enable bit (big-endian 38, vector index 25) and all other state outside the cleared mask survive an interrupt followed by a return unchanged.
- R8: After a return, the machine state has zero in every cause position, including the translation-miss indicators at big-endian 44-47, even when the saved-state word holds ones there.
- R9: The cycle after a return strobe without an interrupt, redirect_valid is high for exactly one cycle, and redirect_pc holds the resume-address register value from the strobe cycle.
- R10: When an interrupt and a return strobe arrive together, the interrupt wins. The machine state becomes ENTRY_MSR, the saved state is built from the filtered return value plus the new causes, the resume register takes intr_pc, and no redirect pulse occurs.
- R11: A software write (sw_wr_en high) updates the register chosen by sw_wr_sel (0 machine state, 1 resume address, 2 saved state) after the edge. Select 3 changes nothing.
- R12: An interrupt overrides a software write to any register in the same cycle, and a return strobe overrides a software write to the machine state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intr_valid | input | 1 | Interrupt taken this cycle |
| intr_pc | input | 64 | Address of the instruction to resume |
| intr_cause_hi | input | 4 | Cause field for big-endian bits 33-36 |
| intr_cause_lo | input | 6 | Cause field for big-endian bits 42-47 |
| rfi_strobe | input | 1 | Return-from-interrupt request |
| sw_wr_en | input | 1 | Software register write enable |
| sw_wr_sel | input | 2 | Write target: 0 state, 1 resume address, 2 saved state, 3 none |
| sw_wr_data | input | 64 | Software write data |
| msr_q | output | 64 | Current machine state |
| srr0_q | output | 64 | Saved resume address |
| srr1_q | output | 64 | Saved state word |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 64 | Fetch redirect address |

## Verification
All three registers sit directly on output ports, so a wrong merge or restore shows on srr1_q or msr_q one edge after the strobe that caused it. A misplaced cause field appears as a wrong bit in srr1_q right after entry. A mask error appears in msr_q right after the return, either as a leaked indicator or as a lost vector-enable bit. Priority mistakes in collision cycles show the same way on the next edge, and so does a missing or doubled redirect pulse.

// File: rtl/exc_state_pkg.sv
package exc_state_pkg;

    localparam int XLEN        = 64;
    localparam int HI_W        = 4;
    localparam int LO_W        = 6;
    localparam int HI_FIRST_BE = 33;
    localparam int LO_FIRST_BE = 42;
    localparam int EE_BE       = 48;
    localparam int PR_BE       = 49;
    localparam int SEL_W       = 2;

    typedef logic [XLEN-1:0] word_t;

    // Big-endian bit number to vector index.
    function automatic int be2le(input int b);
        return XLEN - 1 - b;
    endfunction

    localparam int HI_LSB = XLEN - 1 - (HI_FIRST_BE + HI_W - 1);
    localparam int LO_LSB = XLEN - 1 - (LO_FIRST_BE + LO_W - 1);
    localparam int EE_LE  = XLEN - 1 - EE_BE;
    localparam int PR_LE  = XLEN - 1 - PR_BE;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } cause_t;

    typedef struct packed {
        logic   valid;
        word_t  pc;
        cause_t cause;
    } intr_req_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_MSR  = 2'd0,
        SEL_SRR0 = 2'd1,
        SEL_SRR1 = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     en;
        reg_sel_e sel;
        word_t    data;
    } sw_wr_t;

    // Positions owned by interrupt cause information.
    function automatic word_t cause_mask();
        word_t m;
        m = '0;
        for (int i = 0; i < HI_W; i++) m[HI_LSB + i] = 1'b1;
        for (int i = 0; i < LO_W; i++) m[LO_LSB + i] = 1'b1;
        return m;
    endfunction

    localparam word_t CAUSE_MASK    = cause_mask();
    localparam word_t ENTRY_DEFAULT = 64'h8000_0000_0000_0000;
    localparam word_t RESET_DEFAULT = 64'h8000_0000_0000_0000;

endpackage

// File: rtl/srr1_merge.sv
module srr1_merge
    import exc_state_pkg::*;
(
    input  word_t  msr_src,
    input  cause_t cause,
    output word_t  merged
);

    word_t placed;

    // Scatter the cause fields into their bit positions.
    for (genvar b = 0; b < XLEN; b++) begin : g_place
        if (b >= HI_LSB && b < HI_LSB + HI_W) begin : g_hi
            assign placed[b] = cause.hi[b - HI_LSB];
        end else if (b >= LO_LSB && b < LO_LSB + LO_W) begin : g_lo
            assign placed[b] = cause.lo[b - LO_LSB];
        end else begin : g_zero
            assign placed[b] = 1'b0;
        end
    end

    // Cause information overlays the state copy; nothing else is dropped.
    always_comb begin
        merged = (msr_src & ~CAUSE_MASK) | placed;
    end

endmodule

// File: rtl/msr_restore_filter.sv
module msr_restore_filter
    import exc_state_pkg::*;
(
    input  word_t saved,
    output word_t restored
);

    for (genvar b = 0; b < XLEN; b++) begin : g_keep
        if (CAUSE_MASK[b]) begin : g_strip
            assign restored[b] = 1'b0;
        end else begin : g_pass
            assign restored[b] = saved[b];
        end
    end

endmodule

// File: rtl/exc_state_file.sv
module exc_state_file
    import exc_state_pkg::*;
#(
    parameter word_t ENTRY_MSR = ENTRY_DEFAULT,
    parameter word_t RESET_MSR = RESET_DEFAULT
) (
    input  logic      clk,
    input  logic      rst,
    input  intr_req_t intr,
    input  logic      rfi,
    input  sw_wr_t    sw,
    input  word_t     msr_restored,
    input  word_t     srr1_built,
    output word_t     msr_q,
    output word_t     srr0_q,
    output word_t     srr1_q,
    output logic      redirect_valid,
    output word_t     redirect_pc
);

    word_t msr_d, srr0_d, srr1_d;
    logic  sw_msr, sw_srr0, sw_srr1;

    always_comb begin
        sw_msr  = sw.en && (sw.sel == SEL_MSR);
        sw_srr0 = sw.en && (sw.sel == SEL_SRR0);
        sw_srr1 = sw.en && (sw.sel == SEL_SRR1);
    end

    // Priority: interrupt, then return, then software write.
    always_comb begin
        msr_d = msr_q;
        if (intr.valid)   msr_d = ENTRY_MSR;
        else if (rfi)     msr_d = msr_restored;
        else if (sw_msr)  msr_d = sw.data;
    end

    always_comb begin
        srr0_d = srr0_q;
        srr1_d = srr1_q;
        if (intr.valid) begin
            srr0_d = intr.pc;
            srr1_d = srr1_built;
        end else begin
            if (sw_srr0) srr0_d = sw.data;
            if (sw_srr1) srr1_d = sw.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msr_q          <= RESET_MSR;
            srr0_q         <= '0;
            srr1_q         <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            msr_q          <= msr_d;
            srr0_q         <= srr0_d;
            srr1_q         <= srr1_d;
            redirect_valid <= rfi && !intr.valid;
            if (rfi && !intr.valid) redirect_pc <= srr0_q;
        end
    end

    // R2
    srr0_capture_chk: assert property (@(posedge clk) disable iff (rst)
        intr.valid |=> srr0_q == $past(intr.pc));

    // R4
    cause_fields_chk: assert property (@(posedge clk) disable iff (rst)
        intr.valid |=> (srr1_q[HI_LSB +: HI_W] == $past(intr.cause.hi)) &&
                       (srr1_q[LO_LSB +: LO_W] == $past(intr.cause.lo)));

    // R3
    msr_copy_chk: assert property (@(posedge clk) disable iff (rst)
        intr.valid && !rfi |=> (srr1_q & ~CAUSE_MASK) == ($past(msr_q) & ~CAUSE_MASK));

    // R5
    entry_guard_chk: assert property (@(posedge clk) disable iff (rst)
        intr.valid |=> !msr_q[EE_LE] && !msr_q[PR_LE]);

    // R6
    restore_value_chk: assert property (@(posedge clk) disable iff (rst)
        rfi && !intr.valid |=> msr_q == ($past(srr1_q) & ~CAUSE_MASK));

    // R8
    no_cause_leak_chk: assert property (@(posedge clk) disable iff (rst)
        rfi && !intr.valid |=> (msr_q & CAUSE_MASK) == '0);

    // R9
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rfi && !intr.valid |=> redirect_valid && redirect_pc == $past(srr0_q));

    // R10
    redirect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        intr.valid |=> !redirect_valid);

endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
    import exc_state_pkg::*;
#(
    parameter word_t ENTRY_MSR = ENTRY_DEFAULT,
    parameter word_t RESET_MSR = RESET_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             intr_valid,
    input  logic [XLEN-1:0]  intr_pc,
    input  logic [HI_W-1:0]  intr_cause_hi,
    input  logic [LO_W-1:0]  intr_cause_lo,
    input  logic             rfi_strobe,
    input  logic             sw_wr_en,
    input  logic [SEL_W-1:0] sw_wr_sel,
    input  logic [XLEN-1:0]  sw_wr_data,
    output logic [XLEN-1:0]  msr_q,
    output logic [XLEN-1:0]  srr0_q,
    output logic [XLEN-1:0]  srr1_q,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc
);

    intr_req_t intr;
    sw_wr_t    sw;
    word_t     msr_restored;
    word_t     msr_src;
    word_t     srr1_built;

    always_comb begin
        intr.valid    = intr_valid;
        intr.pc       = intr_pc;
        intr.cause.hi = intr_cause_hi;
        intr.cause.lo = intr_cause_lo;
        sw.en         = sw_wr_en;
        sw.sel        = reg_sel_e'(sw_wr_sel);
        sw.data       = sw_wr_data;
    end

    msr_restore_filter u_filter (
        .saved    (srr1_q),
        .restored (msr_restored)
    );

    // A return in the same cycle completes first; the interrupt saves its result.
    always_comb begin
        msr_src = rfi_strobe ? msr_restored : msr_q;
    end

    srr1_merge u_merge (
        .msr_src (msr_src),
        .cause   (intr.cause),
        .merged  (srr1_built)
    );

    exc_state_file #(
        .ENTRY_MSR (ENTRY_MSR),
        .RESET_MSR (RESET_MSR)
    ) u_file (
        .clk            (clk),
        .rst            (rst),
        .intr           (intr),
        .rfi            (rfi_strobe),
        .sw             (sw),
        .msr_restored   (msr_restored),
        .srr1_built     (srr1_built),
        .msr_q          (msr_q),
        .srr0_q         (srr0_q),
        .srr1_q         (srr1_q),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

endmodule

// File: tb/exc_state_unit_test.sv
module exc_state_unit_test;

    localparam logic [63:0] MASK    = 64'h0000_0000_783F_0000;
    localparam logic [63:0] ENTRY_V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] RESET_V = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        intr_valid;
    logic [63:0] intr_pc;
    logic [3:0]  intr_cause_hi;
    logic [5:0]  intr_cause_lo;
    logic        rfi_strobe;
    logic        sw_wr_en;
    logic [1:0]  sw_wr_sel;
    logic [63:0] sw_wr_data;
    logic [63:0] msr_q, srr0_q, srr1_q, redirect_pc;
    logic        redirect_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exc_state_unit uut (
        .clk(clk), .rst(rst),
        .intr_valid(intr_valid), .intr_pc(intr_pc),
        .intr_cause_hi(intr_cause_hi), .intr_cause_lo(intr_cause_lo),
        .rfi_strobe(rfi_strobe),
        .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
        .msr_q(msr_q), .srr0_q(srr0_q), .srr1_q(srr1_q),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    function automatic logic [63:0] exp_srr1(input logic [63:0] m,
                                             input logic [3:0] hi,
                                             input logic [5:0] lo);
        logic [63:0] r;
        r = m & ~MASK;
        for (int k = 0; k < 4; k++) r[63 - (33 + k)] = hi[3 - k];
        for (int k = 0; k < 6; k++) r[63 - (42 + k)] = lo[5 - k];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        intr_valid = 0; intr_pc = '0; intr_cause_hi = '0; intr_cause_lo = '0;
        rfi_strobe = 0; sw_wr_en = 0; sw_wr_sel = 2'd3; sw_wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [63:0] d);
        sw_wr_en = 1; sw_wr_sel = sel; sw_wr_data = d;
        step();
        clear_inputs();
    endtask

    task automatic t_reset();
        rst = 1; clear_inputs();
        step(); step();
        chk("R1 msr", msr_q, RESET_V);
        chk("R1 srr0", srr0_q, '0);
        chk("R1 srr1", srr1_q, '0);
        chk("R1 redirect_valid", {63'd0, redirect_valid}, 64'd0);
        rst = 0;
        step();
    endtask

    task automatic t_entry(input logic [63:0] m, input logic [63:0] pc,
                           input logic [3:0] hi, input logic [5:0] lo);
        sw_write(2'd0, m);
        intr_valid = 1; intr_pc = pc; intr_cause_hi = hi; intr_cause_lo = lo;
        step();
        clear_inputs();
        chk("R2 srr0", srr0_q, pc);
        chk("R3 state copy", srr1_q & ~MASK, m & ~MASK);
        chk("R4 cause fields", srr1_q, exp_srr1(m, hi, lo));
        chk("R5 entry msr", msr_q, ENTRY_V);
        chk("R5 ee/pr clear", {62'd0, msr_q[63-48], msr_q[63-49]}, 64'd0);
    endtask

    task automatic t_return();
        sw_write(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        sw_write(2'd1, 64'h0000_0000_000A_BCD0);
        rfi_strobe = 1;
        step();
        clear_inputs();
        chk("R6 restored msr", msr_q, ~MASK);
        chk("R8 no cause bits", msr_q & MASK, 64'd0);
        chk("R9 redirect valid", {63'd0, redirect_valid}, 64'd1);
        chk("R9 redirect pc", redirect_pc, 64'h0000_0000_000A_BCD0);
        step();
        chk("R9 single pulse", {63'd0, redirect_valid}, 64'd0);
    endtask

    task automatic t_roundtrip();
        logic [63:0] orig;
        orig = 64'h8000_0000_0200_D032;
        sw_write(2'd0, orig);
        intr_valid = 1; intr_pc = 64'h4000; intr_cause_hi = 4'hF; intr_cause_lo = 6'h0F;
        step();
        clear_inputs();
        chk("R8 tlb bits in srr1", srr1_q & MASK, 64'h0000_0000_780F_0000);
        rfi_strobe = 1;
        step();
        clear_inputs();
        chk("R7 state round trip", msr_q, orig);
        chk("R7 vector enable bit", {63'd0, msr_q[25]}, 64'd1);
        chk("R8 tlb bits dropped", msr_q & MASK, 64'd0);
    endtask

    task automatic t_collide();
        logic [63:0] p;
        p = 64'h1234_5678_FFFF_ABCD;
        sw_write(2'd2, p);
        sw_write(2'd1, 64'h7000);
        intr_valid = 1; rfi_strobe = 1; intr_pc = 64'h9000;
        intr_cause_hi = 4'b0101; intr_cause_lo = 6'b100001;
        step();
        clear_inputs();
        chk("R10 msr entry", msr_q, ENTRY_V);
        chk("R10 srr1 from filtered", srr1_q, exp_srr1(p & ~MASK, 4'b0101, 6'b100001));
        chk("R10 srr0", srr0_q, 64'h9000);
        chk("R10 no redirect", {63'd0, redirect_valid}, 64'd0);
    endtask

    task automatic t_sw();
        logic [63:0] m0, s0, s1;
        sw_write(2'd0, 64'hAAAA_5555_0000_1111);
        chk("R11 write msr", msr_q, 64'hAAAA_5555_0000_1111);
        sw_write(2'd1, 64'h2222);
        chk("R11 write srr0", srr0_q, 64'h2222);
        sw_write(2'd2, 64'h3333_0000_783F_0001);
        chk("R11 write srr1", srr1_q, 64'h3333_0000_783F_0001);
        m0 = msr_q; s0 = srr0_q; s1 = srr1_q;
        sw_write(2'd3, 64'hDEAD_BEEF_DEAD_BEEF);
        chk("R11 sel3 msr", msr_q, m0);
        chk("R11 sel3 srr0", srr0_q, s0);
        chk("R11 sel3 srr1", srr1_q, s1);
        // interrupt beats software write to msr
        intr_valid = 1; intr_pc = 64'h5000;
        sw_wr_en = 1; sw_wr_sel = 2'd0; sw_wr_data = 64'hFFFF;
        step();
        clear_inputs();
        chk("R12 intr over sw msr", msr_q, ENTRY_V);
        // interrupt beats software write to srr0
        intr_valid = 1; intr_pc = 64'h6000;
        sw_wr_en = 1; sw_wr_sel = 2'd1; sw_wr_data = 64'h1;
        step();
        clear_inputs();
        chk("R12 intr over sw srr0", srr0_q, 64'h6000);
        // return beats software write to msr
        sw_write(2'd2, 64'h0000_0001_FFFF_FFFF);
        rfi_strobe = 1; sw_wr_en = 1; sw_wr_sel = 2'd0; sw_wr_data = 64'h77;
        step();
        clear_inputs();
        chk("R12 rfi over sw msr", msr_q, 64'h0000_0001_87C0_FFFF);
        step();
    endtask

    initial begin
        t_reset();
        t_entry(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 4'b1010, 6'b010110);
        t_entry(64'h0, 64'h8888, 4'hF, 6'h3F);
        t_return();
        t_roundtrip();
        t_collide();
        t_sw();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule